// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs a single-channel 12-bit serial converter that has no busy or end-of-conversion pin. On an accepted start request it raises a conversion-start strobe. Because the converter cannot report when it is finished, the block assumes the conversion is complete once a fixed number of system clock cycles has passed. It then produces exactly sixteen serial clock pulses and shifts the returned bits into a 12-bit sample register. The block signals each new sample with a one-cycle valid pulse.

All timing is counted in system clock cycles and set by parameters: conversion time, strobe pulse length, serial clock half period and guard time. The `READ_DURING` parameter selects between two modes:

- **Read after conversion** (`READ_DURING = 0`): the strobe stays high for the whole conversion time, and the read starts after it falls.
- **Read during conversion** (`READ_DURING = 0` is off, `1` is on): the strobe is only a short pulse, and the read starts after that pulse falls while the conversion is still running.

In both modes the read begins only after the strobe's falling edge. The converter clears its output register on that edge, so a read never spans it. After the last serial clock, the block keeps a guard interval before the next strobe can rise. Any start request that arrives before the block is idle again is rejected.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero after that edge: `conv_strb`, `ser_clk`, `req_reject`, `sample_valid` and `sample_data`.
- R2: If `start_req` is high at an edge while the block is idle, `conv_strb` goes high after that same edge. No other event raises `conv_strb`.
- R3: `conv_strb` stays high for exactly `CONV_CYC` cycles when `READ_DURING = 0`, and for exactly `PULSE_CYC` cycles when `READ_DURING = 1`. `ser_clk` is never high while `conv_strb` is high.
- R4: Each read is exactly 16 `ser_clk` pulses, each high for `SCLK_HALF` cycles and low for `SCLK_HALF` cycles. The first rising edge comes `SCLK_HALF` cycles after `conv_strb` falls. `ser_clk` idles low.
- R5: `ser_din` is sampled at the system clock edge that takes `ser_clk` low. The converter is assumed to shift on the rising edge. Bits arrive most significant first. `sample_data` holds the last 12 of the 16 bits, and the first 4 bits are discarded.
- R6: `sample_valid` is high for exactly one cycle, on the cycle after the 16th falling edge of `ser_clk`. `sample_data` changes only in that cycle and holds its value at all other times.
- R7: After the last falling edge of `ser_clk` in a read, the next rising edge of `conv_strb` comes at least `GUARD_CYC + 1` cycles later.
- R8: Two successive rising edges of `conv_strb` are at least `CONV_CYC + 2` cycles apart. In read-during mode, the block waits for whichever is later: the end of the guard interval or the end of the conversion time.
- R9: If `start_req` is high at an edge while the block is not idle, `req_reject` pulses high for the next cycle and the request has no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to start a conversion |
| req_reject | output | 1 | One-cycle pulse: a request arrived while the block was busy and was refused |
| conv_strb | output | 1 | Conversion-start strobe to the converter; its rising edge starts a conversion |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_din | input | 1 | Serial data from the converter |
| sample_data | output | SAMPLE_W | Most recently captured sample |
| sample_valid | output | 1 | One-cycle pulse marking a new `sample_data` |

## Verification
The assertions assume the following about the block's inputs:

- `start_req` is synchronous to `clk`.
- `ser_din` settles within one `SCLK_HALF` interval after a rising edge of `ser_clk` and holds until the following falling edge.
- `GUARD_CYC` is at least 1 and `PULSE_CYC` is shorter than `CONV_CYC`.

The stimulus meets these assumptions in three ways:

- It changes `start_req` and the frame pattern only on the falling edge of `clk`.
- Its converter model moves to the next bit on each rising edge of `ser_clk` and returns to the first bit when `conv_strb` falls.
- It keeps the default timing, which meets both parameter conditions.

Back-to-back requests hold `start_req` high without a break, so every new strobe starts at the earliest cycle the guard and conversion timers allow.

// File: rtl/acs_pkg.sv
// Shared types for the serial ADC conversion sequencer.
package acs_pkg;

    // Sequencer phase: waiting, converting, reading, guarding.
    typedef enum logic [1:0] {
        ACS_IDLE  = 2'd0,
        ACS_CONV  = 2'd1,
        ACS_READ  = 2'd2,
        ACS_GUARD = 2'd3
    } acs_state_e;

endpackage

// File: rtl/acs_fsm.sv
// Conversion sequencer FSM.
// Accepts a start request only when idle and raises the strobe for STRB_HI
// cycles. It then runs the read and holds the guard interval. In read-during
// mode it also waits for the conversion time to elapse before returning idle.
// Assumes GUARD_CYC >= 1 and PULSE_CYC < CONV_CYC.
module acs_fsm
    import acs_pkg::*;
#(
    parameter int CONV_CYC    = 600,
    parameter int PULSE_CYC   = 4,
    parameter int GUARD_CYC   = 60,
    parameter bit READ_DURING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic read_last,
    output logic conv_strb,
    output logic req_reject,
    output logic read_run
);

    localparam int STRB_HI = READ_DURING ? PULSE_CYC : CONV_CYC;
    localparam int EL_W    = $clog2(CONV_CYC + 1);
    localparam int G_W     = $clog2(GUARD_CYC + 1);

    acs_state_e        state;
    logic [EL_W-1:0]   elapsed;
    logic [G_W-1:0]    gcnt;
    logic              conv_done;

    // Conversion-complete condition: only read-during mode must wait for it.
    generate
        if (READ_DURING) begin : g_wait_conv
            assign conv_done = (elapsed == EL_W'(CONV_CYC));
        end else begin : g_conv_over
            assign conv_done = 1'b1;
        end
    endgenerate

    // Refusal pulse for requests that arrive while not idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_reject <= 1'b0;
        end else begin
            req_reject <= start_req && (state != ACS_IDLE);
        end
    end

    // Cycles since the strobe rose, saturating at the conversion time.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ACS_IDLE) begin
            elapsed <= '0;
        end else if (elapsed != EL_W'(CONV_CYC)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Phase sequencing and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ACS_IDLE;
            conv_strb <= 1'b0;
            gcnt      <= '0;
        end else begin
            case (state)
                ACS_IDLE: begin
                    if (start_req) begin
                        state     <= ACS_CONV;
                        conv_strb <= 1'b1;
                    end
                end
                ACS_CONV: begin
                    if (elapsed == EL_W'(STRB_HI - 1)) begin
                        conv_strb <= 1'b0;
                        state     <= ACS_READ;
                    end
                end
                ACS_READ: begin
                    if (read_last) begin
                        state <= ACS_GUARD;
                        gcnt  <= '0;
                    end
                end
                ACS_GUARD: begin
                    if (gcnt == G_W'(GUARD_CYC - 1)) begin
                        if (conv_done) begin
                            state <= ACS_IDLE;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= ACS_IDLE;
            endcase
        end
    end

    assign read_run = (state == ACS_READ);

endmodule

// File: rtl/acs_sclk_gen.sv
// Serial clock generator for one read frame.
// While run is high it produces FRAME pulses. Each pulse starts with a low
// half of HALF cycles and then a high half of HALF cycles. cap flags the cycle
// whose edge drives ser_clk low, which is where data is sampled. last marks
// the cap of the final bit. When run is low the generator clears and idles low.
module acs_sclk_gen #(
    parameter int HALF  = 6,
    parameter int FRAME = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic cap,
    output logic last
);

    localparam int PH_W  = $clog2(HALF + 1);
    localparam int BIT_W = $clog2(FRAME);

    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bit_idx;
    logic             half_end;

    assign half_end = (phase == PH_W'(HALF - 1));
    assign cap      = run && sclk && half_end;
    assign last     = cap && (bit_idx == BIT_W'(FRAME - 1));

    // Half-period timing, clock toggling and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase   <= '0;
            sclk    <= 1'b0;
            bit_idx <= '0;
        end else if (half_end) begin
            phase <= '0;
            sclk  <= ~sclk;
            if (sclk) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/acs_shifter.sv
// Sample capture register.
// Shifts ser_din in MSB first on each cap. On the final bit it loads the
// newest W bits into the sample and pulses valid. Earlier bits of the frame
// fall off the top of the shift path. Assumes W >= 3.
module acs_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         last,
    input  logic         din,
    output logic [W-1:0] sample,
    output logic         valid
);

    logic [W-2:0] shreg;

    // Shift path holding the W-1 most recent bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (cap) begin
            shreg <= {shreg[W-3:0], din};
        end
    end

    // Sample load and valid pulse on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= last;
            if (last) begin
                sample <= {shreg, din};
            end
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Serial ADC conversion sequencer, top level.
// Drives the start strobe and serial clock of a converter that has no
// completion pin, and collects each 12-bit result. Assumes ser_din changes
// on the rising edge of ser_clk and settles within one half period.
module adc_conv_seq #(
    parameter int CONV_CYC    = 600,
    parameter int PULSE_CYC   = 4,
    parameter int SCLK_HALF   = 6,
    parameter int GUARD_CYC   = 60,
    parameter bit READ_DURING = 1'b0,
    parameter int FRAME_BITS  = 16,
    parameter int SAMPLE_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    output logic                req_reject,
    output logic                conv_strb,
    output logic                ser_clk,
    input  logic                ser_din,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic                sample_valid
);

    logic read_run;
    logic cap;
    logic last;

    acs_fsm #(
        .CONV_CYC    (CONV_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .GUARD_CYC   (GUARD_CYC),
        .READ_DURING (READ_DURING)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .read_last  (last),
        .conv_strb  (conv_strb),
        .req_reject (req_reject),
        .read_run   (read_run)
    );

    acs_sclk_gen #(
        .HALF  (SCLK_HALF),
        .FRAME (FRAME_BITS)
    ) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (read_run),
        .sclk  (ser_clk),
        .cap   (cap),
        .last  (last)
    );

    acs_shifter #(
        .W (SAMPLE_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .last   (last),
        .din    (ser_din),
        .sample (sample_data),
        .valid  (sample_valid)
    );

endmodule

// File: rtl/acs_checker.sv
// Property checker for adc_conv_seq, bound to every instance.
// It keeps its own counters of cycles since the last serial clock fall and
// since the last strobe rise.
module acs_checker #(
    parameter int CONV_CYC  = 600,
    parameter int GUARD_CYC = 60,
    parameter int SAMPLE_W  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_req,
    input logic                req_reject,
    input logic                conv_strb,
    input logic                ser_clk,
    input logic [SAMPLE_W-1:0] sample_data,
    input logic                sample_valid
);

    localparam int GAP_W = $clog2(GUARD_CYC + 1);
    localparam int SIN_W = $clog2(CONV_CYC + 2);

    logic             prev_sclk;
    logic             prev_strb;
    logic [GAP_W-1:0] gap_cnt;
    logic [SIN_W-1:0] since_cnt;

    // Saturating distances from the last serial clock fall and strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            prev_strb <= 1'b0;
            gap_cnt   <= GAP_W'(GUARD_CYC);
            since_cnt <= SIN_W'(CONV_CYC + 1);
        end else begin
            prev_sclk <= ser_clk;
            prev_strb <= conv_strb;
            if (prev_sclk && !ser_clk) begin
                gap_cnt <= '0;
            end else if (gap_cnt != GAP_W'(GUARD_CYC)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (conv_strb && !prev_strb) begin
                since_cnt <= '0;
            end else if (since_cnt != SIN_W'(CONV_CYC + 1)) begin
                since_cnt <= since_cnt + 1'b1;
            end
        end
    end

    // R2
    strb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_strb) |-> ($past(start_req) && !req_reject));

    // R3
    strb_no_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strb |-> !ser_clk);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_data));

    // R7
    guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_strb) |-> (gap_cnt >= GAP_W'(GUARD_CYC)));

    // R8
    conv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_strb) |-> (since_cnt >= SIN_W'(CONV_CYC + 1)));

    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> $past(start_req));

endmodule

bind adc_conv_seq acs_checker #(
    .CONV_CYC  (CONV_CYC),
    .GUARD_CYC (GUARD_CYC),
    .SAMPLE_W  (SAMPLE_W)
) u_acs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .req_reject   (req_reject),
    .conv_strb    (conv_strb),
    .ser_clk      (ser_clk),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
);

// File: tb/test_adc_conv_seq.sv
// Per-instance lane: converter model, behavioural reference and comparison.
module acs_lane #(
    parameter int    CONV   = 600,
    parameter int    PULSE  = 4,
    parameter int    HALF   = 6,
    parameter int    GUARD  = 60,
    parameter bit    DURING = 1'b0,
    parameter string TAG    = "after"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic [15:0] frame,
    input  logic        conv_strb,
    input  logic        ser_clk,
    input  logic        req_reject,
    input  logic [11:0] sample_data,
    input  logic        sample_valid,
    output logic        ser_din,
    output int          n_chk,
    output int          n_fail
);
    localparam int HI    = DURING ? PULSE : CONV;
    localparam int RDEND = HI + 32 * HALF;
    localparam int IDLEK = (RDEND + GUARD > CONV + 1) ? RDEND + GUARD : CONV + 1;

    // converter model: latches frame on strobe rise, restarts on strobe fall
    logic [15:0] word = 16'h0;
    int idx = 0;
    always @(posedge conv_strb) word = frame;
    always @(negedge conv_strb) idx = 0;
    always @(posedge ser_clk) idx = idx + 1;
    assign ser_din = (idx >= 1 && idx <= 16) ? word[16 - idx] : 1'b0;

    // reference model
    bit busy = 0;
    int k = 0;
    bit e_strb = 0, e_sclk = 0, e_valid = 0, e_rej = 0;
    logic [11:0] e_sample = '0;
    logic [11:0] q[$];
    int cyc = 0;

    always @(posedge clk) begin
        int j;
        cyc = cyc + 1;
        if (!rst_n) begin
            busy = 0; k = 0; e_rej = 0; e_sample = '0; q.delete();
        end else if (busy) begin
            e_rej = start_req;
            k = k + 1;
            if (k == IDLEK) busy = 0;
        end else begin
            e_rej = 0;
            if (start_req) begin
                busy = 1; k = 0; q.push_back(frame[11:0]);
            end
        end
        j = k - HI;
        e_strb  = busy && (k < HI);
        e_sclk  = busy && (j > 0) && (j < 32 * HALF) && ((j / HALF) % 2 == 1);
        e_valid = busy && (k == RDEND);
        if (e_valid && q.size() > 0) e_sample = q.pop_front();
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s %s: actual %0h expected %0h", TAG, rq, what, act, exp);
        end
    endtask

    bit prev_sclk = 0, prev_strb = 0;
    int last_fall = -1, last_rise = -1, rises = 0;

    initial begin
        n_chk = 0;
        n_fail = 0;
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && rst_n) begin
            chk(conv_strb == e_strb, "R2 R3", "conv_strb", conv_strb, e_strb);
            chk(ser_clk == e_sclk, "R4", "ser_clk", ser_clk, e_sclk);
            chk(sample_valid == e_valid, "R6", "sample_valid", sample_valid, e_valid);
            chk(sample_data == e_sample, "R5", "sample_data", sample_data, e_sample);
            chk(req_reject == e_rej, "R9", "req_reject", req_reject, e_rej);
            if (prev_sclk && !ser_clk) last_fall = cyc;
            if (ser_clk && !prev_sclk) rises = rises + 1;
            if (conv_strb && !prev_strb) begin
                if (last_rise >= 0) begin
                    chk(cyc - last_rise >= CONV + 2, "R8", "rise spacing", cyc - last_rise, CONV + 2);
                    chk(rises == 16, "R4", "pulses per read", rises, 16);
                    chk(cyc - last_fall >= GUARD + 1, "R7", "guard gap", cyc - last_fall, GUARD + 1);
                end
                last_rise = cyc;
                rises = 0;
            end
            prev_sclk = ser_clk;
            prev_strb = conv_strb;
        end
    end
endmodule

module test_adc_conv_seq;
    localparam int CONV  = 600;
    localparam int PULSE = 4;
    localparam int HALF  = 6;
    localparam int GUARD = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic [15:0] frame = 16'h0;

    logic        a_rej, a_strb, a_sclk, a_din, a_valid;
    logic [11:0] a_data;
    logic        d_rej, d_strb, d_sclk, d_din, d_valid;
    logic [11:0] d_data;
    int a_chk, a_fail, d_chk, d_fail;
    int t_chk = 0, t_fail = 0;

    always #5 clk = ~clk;

    adc_conv_seq #(.CONV_CYC(CONV), .PULSE_CYC(PULSE), .SCLK_HALF(HALF),
                   .GUARD_CYC(GUARD), .READ_DURING(1'b0)) i_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .req_reject(a_rej),
        .conv_strb(a_strb), .ser_clk(a_sclk), .ser_din(a_din),
        .sample_data(a_data), .sample_valid(a_valid));

    adc_conv_seq #(.CONV_CYC(CONV), .PULSE_CYC(PULSE), .SCLK_HALF(HALF),
                   .GUARD_CYC(GUARD), .READ_DURING(1'b1)) i_adc_conv_seq_rd (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .req_reject(d_rej),
        .conv_strb(d_strb), .ser_clk(d_sclk), .ser_din(d_din),
        .sample_data(d_data), .sample_valid(d_valid));

    acs_lane #(.CONV(CONV), .PULSE(PULSE), .HALF(HALF), .GUARD(GUARD),
               .DURING(1'b0), .TAG("after")) u_lane_a (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .frame(frame),
        .conv_strb(a_strb), .ser_clk(a_sclk), .req_reject(a_rej),
        .sample_data(a_data), .sample_valid(a_valid), .ser_din(a_din),
        .n_chk(a_chk), .n_fail(a_fail));

    acs_lane #(.CONV(CONV), .PULSE(PULSE), .HALF(HALF), .GUARD(GUARD),
               .DURING(1'b1), .TAG("during")) u_lane_d (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .frame(frame),
        .conv_strb(d_strb), .ser_clk(d_sclk), .req_reject(d_rej),
        .sample_data(d_data), .sample_valid(d_valid), .ser_din(d_din),
        .n_chk(d_chk), .n_fail(d_fail));

    task automatic tchk(input bit ok, input string what, input longint act);
        t_chk = t_chk + 1;
        if (!ok) begin
            t_fail = t_fail + 1;
            $display("FAIL R1 %s: actual %0h expected 0", what, act);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 t_chk + a_chk + d_chk, t_fail + a_fail + d_fail);
        $finish;
    endtask

    task automatic request(input logic [15:0] f);
        @(negedge clk);
        frame = f;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        t_chk = t_chk + 1;
        t_fail = t_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs cleared while reset is held, even with a request pending
        start_req = 1'b1;
        repeat (4) @(negedge clk);
        tchk(a_strb == 0 && d_strb == 0, "conv_strb", {a_strb, d_strb});
        tchk(a_sclk == 0 && d_sclk == 0, "ser_clk", {a_sclk, d_sclk});
        tchk(a_rej == 0 && d_rej == 0, "req_reject", {a_rej, d_rej});
        tchk(a_valid == 0 && d_valid == 0, "sample_valid", {a_valid, d_valid});
        tchk(a_data == 0 && d_data == 0, "sample_data", {a_data, d_data});
        start_req = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // single conversion, with stray requests while busy (R9)
        request(16'hA5C3);
        repeat (40) @(negedge clk);
        request(16'h1111);
        repeat (650) @(negedge clk);
        request(16'h2222);
        repeat (400) @(negedge clk);

        // leading bits set must be discarded; all-ones result (R5)
        request(16'hF000);
        repeat (1000) @(negedge clk);
        request(16'h0FFF);
        repeat (1000) @(negedge clk);

        // back-to-back requests at the earliest legal cycle (R7, R8)
        for (int n = 0; n < 12000; n++) begin
            @(negedge clk);
            start_req = 1'b1;
            frame = {frame[14:0], frame[15] ^ frame[13] ^ frame[12] ^ frame[10]} ^ 16'h0001;
        end
        @(negedge clk);
        start_req = 1'b0;
        repeat (1500) @(negedge clk);
        finish_run();
    end
endmodule